// File: doc/BRIEF.md
# Programmable Interlaced Sync Timing Generator

This block is a master-mode raster timer for an interlaced video frame. A free-running pixel counter and a line counter walk the frame from line 1, pixel 0. Two active-low registered sync outputs are derived from them. The first is a horizontal sync pulse. The second is either a field-level indicator or a separate vertical sync pulse; the output style is chosen by a mode input. A pixel data bus passes through a short programmable delay so that it lines up with the sync pulses.

All timing comes from one packed 8-bit word. Coded 2-bit fields pick pulse widths from a non-linear set of clock counts, an edge offset from the start of the line, and a data skew. In field mode, one bit adds half a line to the offset of the edge that enters the second field. The word and the mode take effect only at a line boundary, so a pulse that is in progress is never cut short. With the default parameters the frame is 625 lines of 1728 clocks, and the second field begins at line 313. The parameters must satisfy LINE_LEN/2 + 144 < LINE_LEN and 1 < FIELD2_LINE <= LINE_CNT.

Top module: `vsync_timing_gen`

## Requirements
- R1: `pixel_o` counts 0 to LINE_LEN-1 and wraps to 0. `line_o` advances when the pixel count wraps and runs 1 to LINE_CNT, then back to 1. `field_o` is 1 exactly while `line_o` >= FIELD2_LINE.
- R2: `hsync_n_o` is low in the cycle after each cycle whose pixel count is below W, where W is chosen by word bits [1:0]: code 0 gives 1, code 1 gives 4, code 2 gives 16 and code 3 gives 128.
- R3: Word bits [3:2] set an edge offset D of 0, 4, 8 or 16 clocks for codes 0 to 3. Every `fv_o` edge is placed relative to pixel 0 by this offset.
- R4: With mode 0 (field level), `fv_o` falls in the cycle after line FIELD2_LINE, pixel D + H. H is LINE_LEN/2 when word bit [4] is 1 and 0 when it is 0. `fv_o` rises in the cycle after line 1, pixel D, and at all other times it holds its value.
- R5: With mode 1 (vertical pulse), `fv_o` is low for V cycles starting in the cycle after line 1, pixel D, and for V cycles starting in the cycle after line FIELD2_LINE, pixel LINE_LEN/2 + D. V is chosen by word bits [5:4] with the same codes as R2. Outside these windows `fv_o` is high.
- R6: `pix_data_o` equals `pix_data_i` from 1+S cycles earlier, where S (0 to 3) is word bits [7:6].
- R7: The word and the mode are sampled only in the cycle in which the pixel count is LINE_LEN-1, and they apply from pixel 0 of the next line. From reset until the first such sample, the word is all zeros and the mode is 0.
- R8: While `rst_n` is low, and without waiting for a clock, `hsync_n_o` and `fv_o` are 1, `pix_data_o` is 0, `line_o` is 1, `pixel_o` is 0 and `field_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| timing_cfg_i | input | 8 | Packed timing word: [1:0] hsync width, [3:2] edge offset, [5:4] vsync width or half-line bit, [7:6] data skew |
| vs_mode_i | input | 1 | 0 selects the field-level output, 1 selects the vertical pulse output |
| pix_data_i | input | DATA_W | Incoming pixel data |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| fv_o | output | 1 | Field level or vertical sync (active low), depending on mode |
| pix_data_o | output | DATA_W | Pixel data after the programmed delay |
| line_o | output | clog2(LINE_CNT+1) | Current line, counted from 1 |
| pixel_o | output | clog2(LINE_LEN) | Current pixel within the line |
| field_o | output | 1 | 0 in the first field, 1 in the second |

## Verification
The properties assume a line longer than 128 clocks, so that the widest horizontal pulse ends inside the line. They also assume that the second field starts on a line other than line 1, so that the quiet lines are well defined. The bench picks a short 300-clock, 11-line frame that meets both conditions while keeping runs brief. It changes the word and the mode only through the ports and at arbitrary points within a line. It never drives the inputs at a clock edge, so each changed word is latched only at the line boundary that the rules define.

// File: rtl/vsync_gen_pkg.sv
package vsync_gen_pkg;

  // Packed timing word, field order fixed by bit position
  typedef struct packed {
    logic [1:0] skew;   // [7:6] data delay in clocks
    logic [1:0] aux;    // [5:4] vsync width code, or [4] half-line flag
    logic [1:0] dly;    // [3:2] edge offset code
    logic [1:0] hsw;    // [1:0] hsync width code
  } tcfg_t;

  typedef enum logic {
    OUT_FIELD = 1'b0,
    OUT_VSYNC = 1'b1
  } fv_mode_e;

  localparam int unsigned SKEW_MAX = 3;

  function automatic logic [7:0] pulse_len(input logic [1:0] code);
    logic [7:0] n;
    case (code)
      2'd0:    n = 8'd1;
      2'd1:    n = 8'd4;
      2'd2:    n = 8'd16;
      default: n = 8'd128;
    endcase
    return n;
  endfunction

  function automatic logic [4:0] edge_dly(input logic [1:0] code);
    logic [4:0] n;
    case (code)
      2'd0:    n = 5'd0;
      2'd1:    n = 5'd4;
      2'd2:    n = 5'd8;
      default: n = 5'd16;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/raster_count.sv
module raster_count #(
  parameter int unsigned LINE_LEN    = 1728,
  parameter int unsigned LINE_CNT    = 625,
  parameter int unsigned FIELD2_LINE = 313,
  parameter int unsigned PIX_W       = $clog2(LINE_LEN),
  parameter int unsigned LN_W        = $clog2(LINE_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PIX_W-1:0] pix_o,
  output logic [LN_W-1:0]  line_o,
  output logic             field_o,
  output logic             line_end_o
);

  logic [PIX_W-1:0] pix_q, pix_d;
  logic [LN_W-1:0]  line_q, line_d;
  logic             field_q, field_d;
  logic             line_end;

  always_comb begin
    line_end = (pix_q == PIX_W'(LINE_LEN - 1));
    pix_d    = line_end ? '0 : pix_q + 1'b1;
    if (line_q == LN_W'(LINE_CNT)) begin
      line_d = LN_W'(1);
    end else begin
      line_d = line_q + 1'b1;
    end
    field_d = (line_d >= LN_W'(FIELD2_LINE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q   <= '0;
      line_q  <= LN_W'(1);
      field_q <= 1'b0;
    end else begin
      pix_q <= pix_d;
      if (line_end) begin
        line_q  <= line_d;
        field_q <= field_d;
      end
    end
  end

  assign pix_o      = pix_q;
  assign line_o     = line_q;
  assign field_o    = field_q;
  assign line_end_o = line_end;

endmodule

// File: rtl/cfg_hold.sv
module cfg_hold
  import vsync_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  tcfg_t    cfg_i,
  input  fv_mode_e mode_i,
  output tcfg_t    cfg_o,
  output fv_mode_e mode_o
);

  tcfg_t    cfg_q, cfg_d;
  fv_mode_e mode_q, mode_d;

  always_comb begin
    cfg_d  = cfg_q;
    mode_d = mode_q;
    if (load_i) begin
      cfg_d  = cfg_i;
      mode_d = mode_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mode_q <= OUT_FIELD;
    end else begin
      cfg_q  <= cfg_d;
      mode_q <= mode_d;
    end
  end

  assign cfg_o  = cfg_q;
  assign mode_o = mode_q;

endmodule

// File: rtl/sync_shaper.sv
module sync_shaper
  import vsync_gen_pkg::*;
#(
  parameter int unsigned LINE_LEN    = 1728,
  parameter int unsigned FIELD2_LINE = 313,
  parameter int unsigned PIX_W       = 11,
  parameter int unsigned LN_W        = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [LN_W-1:0]  line_i,
  input  logic [1:0]       hs_code_i,
  input  logic [1:0]       dly_code_i,
  input  logic [1:0]       aux_code_i,
  input  fv_mode_e         mode_i,
  output logic             hsync_n_o,
  output logic             fv_o
);

  localparam int unsigned CW        = PIX_W + 2;
  localparam int unsigned HALF_LINE = LINE_LEN / 2;

  logic [CW-1:0] p, hw, dl, vlen, rise_at;
  logic [CW-1:0] v1_end, v2_start, v2_end;
  logic          at_top, at_mid;
  logic          hs_q, hs_d, fv_q, fv_d;

  always_comb begin
    p        = CW'(pix_i);
    hw       = CW'(pulse_len(hs_code_i));
    dl       = CW'(edge_dly(dly_code_i));
    vlen     = CW'(pulse_len(aux_code_i));
    rise_at  = dl + (aux_code_i[0] ? CW'(HALF_LINE) : '0);
    v1_end   = dl + vlen;
    v2_start = dl + CW'(HALF_LINE);
    v2_end   = v2_start + vlen;
    at_top   = (line_i == LN_W'(1));
    at_mid   = (line_i == LN_W'(FIELD2_LINE));

    hs_d = ~(p < hw);

    if (mode_i == OUT_VSYNC) begin
      fv_d = ~((at_top && (p >= dl) && (p < v1_end)) ||
               (at_mid && (p >= v2_start) && (p < v2_end)));
    end else begin
      fv_d = fv_q;
      if (at_mid && (p == rise_at)) begin
        fv_d = 1'b0;
      end else if (at_top && (p == dl)) begin
        fv_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b1;
      fv_q <= 1'b1;
    end else begin
      hs_q <= hs_d;
      fv_q <= fv_d;
    end
  end

  assign hsync_n_o = hs_q;
  assign fv_o      = fv_q;

endmodule

// File: rtl/pix_skew.sv
module pix_skew
  import vsync_gen_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din_i,
  input  logic [1:0]        skew_i,
  output logic [DATA_W-1:0] dout_o
);

  logic [DATA_W-1:0] tap_q [SKEW_MAX];
  logic [DATA_W-1:0] out_q, out_d;

  for (genvar k = 0; k < SKEW_MAX; k++) begin : g_tap
    logic [DATA_W-1:0] src;
    if (k == 0) begin : g_first
      assign src = din_i;
    end else begin : g_next
      assign src = tap_q[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tap_q[k] <= '0;
      end else begin
        tap_q[k] <= src;
      end
    end
  end

  always_comb begin
    case (skew_i)
      2'd0:    out_d = din_i;
      2'd1:    out_d = tap_q[0];
      2'd2:    out_d = tap_q[1];
      default: out_d = tap_q[2];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else begin
      out_q <= out_d;
    end
  end

  assign dout_o = out_q;

endmodule

// File: rtl/vsync_timing_gen.sv
module vsync_timing_gen
  import vsync_gen_pkg::*;
#(
  parameter int unsigned LINE_LEN    = 1728,
  parameter int unsigned LINE_CNT    = 625,
  parameter int unsigned FIELD2_LINE = 313,
  parameter int unsigned DATA_W      = 16,
  localparam int unsigned PIX_W      = $clog2(LINE_LEN),
  localparam int unsigned LN_W       = $clog2(LINE_CNT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        timing_cfg_i,
  input  logic              vs_mode_i,
  input  logic [DATA_W-1:0] pix_data_i,
  output logic              hsync_n_o,
  output logic              fv_o,
  output logic [DATA_W-1:0] pix_data_o,
  output logic [LN_W-1:0]   line_o,
  output logic [PIX_W-1:0]  pixel_o,
  output logic              field_o
);

  logic     line_end;
  tcfg_t    act_cfg;
  fv_mode_e act_mode;

  raster_count #(
    .LINE_LEN    (LINE_LEN),
    .LINE_CNT    (LINE_CNT),
    .FIELD2_LINE (FIELD2_LINE),
    .PIX_W       (PIX_W),
    .LN_W        (LN_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_o      (pixel_o),
    .line_o     (line_o),
    .field_o    (field_o),
    .line_end_o (line_end)
  );

  cfg_hold u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (line_end),
    .cfg_i  (tcfg_t'(timing_cfg_i)),
    .mode_i (fv_mode_e'(vs_mode_i)),
    .cfg_o  (act_cfg),
    .mode_o (act_mode)
  );

  sync_shaper #(
    .LINE_LEN    (LINE_LEN),
    .FIELD2_LINE (FIELD2_LINE),
    .PIX_W       (PIX_W),
    .LN_W        (LN_W)
  ) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_i      (pixel_o),
    .line_i     (line_o),
    .hs_code_i  (act_cfg.hsw),
    .dly_code_i (act_cfg.dly),
    .aux_code_i (act_cfg.aux),
    .mode_i     (act_mode),
    .hsync_n_o  (hsync_n_o),
    .fv_o       (fv_o)
  );

  pix_skew #(
    .DATA_W (DATA_W)
  ) u_skew (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_i  (pix_data_i),
    .skew_i (act_cfg.skew),
    .dout_o (pix_data_o)
  );

endmodule

// File: rtl/vsync_timing_gen_chk.sv
module vsync_timing_gen_chk
  import vsync_gen_pkg::*;
#(
  parameter int unsigned LINE_LEN    = 1728,
  parameter int unsigned LINE_CNT    = 625,
  parameter int unsigned FIELD2_LINE = 313,
  localparam int unsigned PIX_W      = $clog2(LINE_LEN),
  localparam int unsigned LN_W       = $clog2(LINE_CNT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PIX_W-1:0] pixel_o,
  input logic [LN_W-1:0]  line_o,
  input logic             hsync_n_o,
  input logic             fv_o,
  input tcfg_t            act_cfg,
  input fv_mode_e         act_mode
);

  AST_PIX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pixel_o < PIX_W'(LINE_LEN)); // R1

  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_o >= LN_W'(1)) && (line_o <= LN_W'(LINE_CNT))); // R1

  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pixel_o != PIX_W'(LINE_LEN - 1)) |=> (pixel_o == $past(pixel_o) + 1'b1)); // R1

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((pixel_o == PIX_W'(LINE_LEN - 1)) && (line_o == LN_W'(LINE_CNT))) |=> (line_o == LN_W'(1))); // R1

  AST_HS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (pixel_o == '0) |=> !hsync_n_o); // R2

  AST_HS_END: assert property (@(posedge clk) disable iff (!rst_n)
    (pixel_o == PIX_W'(128)) |=> hsync_n_o); // R2

  AST_FIELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_mode == OUT_FIELD) && (line_o != LN_W'(1)) && (line_o != LN_W'(FIELD2_LINE)))
      |=> $stable(fv_o)); // R4

  AST_VS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_mode == OUT_VSYNC) && (line_o != LN_W'(1)) && (line_o != LN_W'(FIELD2_LINE)))
      |=> fv_o); // R5

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pixel_o != '0) |-> ($stable(act_cfg) && $stable(act_mode))); // R7

endmodule

bind vsync_timing_gen vsync_timing_gen_chk #(
  .LINE_LEN    (LINE_LEN),
  .LINE_CNT    (LINE_CNT),
  .FIELD2_LINE (FIELD2_LINE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pixel_o   (pixel_o),
  .line_o    (line_o),
  .hsync_n_o (hsync_n_o),
  .fv_o      (fv_o),
  .act_cfg   (act_cfg),
  .act_mode  (act_mode)
);

// File: tb/vsync_timing_gen_test.sv
`timescale 1ns/100ps
module vsync_timing_gen_test;

  localparam int LL   = 300;
  localparam int LC   = 11;
  localparam int F2   = 6;
  localparam int DW   = 8;
  localparam int HALF = LL / 2;
  localparam int PW   = $clog2(LL);
  localparam int LW   = $clog2(LC + 1);

  typedef struct packed {
    logic       mode;
    logic [7:0] cfg;
    int         hw;     // expected hsync low clocks per line
    int         fpix;   // expected pixel_o when fv_o is first seen low
    int         fline;  // line on which that fall is checked
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 8'h00,   1,   1, F2},
    '{1'b0, 8'h45,   4,   5, F2},
    '{1'b0, 8'h9A,  16, 159, F2},
    '{1'b0, 8'hFF, 128, 167, F2},
    '{1'b1, 8'h00,   1,   1,  1},
    '{1'b1, 8'h65,   4,   5,  1},
    '{1'b1, 8'hB6,  16,   5,  1},
    '{1'b1, 8'hDB, 128,   9,  1}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    cfg;
  logic          mode;
  logic [DW-1:0] din;
  logic          hsync_n, fv, field;
  logic [DW-1:0] dout;
  logic [LW-1:0] line;
  logic [PW-1:0] pixel;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vsync_timing_gen #(
    .LINE_LEN(LL), .LINE_CNT(LC), .FIELD2_LINE(F2), .DATA_W(DW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .timing_cfg_i(cfg), .vs_mode_i(mode),
    .pix_data_i(din), .hsync_n_o(hsync_n), .fv_o(fv), .pix_data_o(dout),
    .line_o(line), .pixel_o(pixel), .field_o(field)
  );

  // Reference model, written from the requirements
  function automatic int w_of(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 4 : (c == 2'd2) ? 16 : 128;
  endfunction
  function automatic int d_of(input logic [1:0] c);
    return (c == 2'd0) ? 0 : (c == 2'd1) ? 4 : (c == 2'd2) ? 8 : 16;
  endfunction

  int m_pix, m_line;
  logic [7:0] m_cfg;
  logic m_mode, m_field, e_hs, e_fv;
  logic [DW-1:0] e_dat, h0, h1, h2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pix <= 0; m_line <= 1; m_cfg <= 8'h00; m_mode <= 1'b0; m_field <= 1'b0;
      e_hs <= 1'b1; e_fv <= 1'b1; e_dat <= '0; h0 <= '0; h1 <= '0; h2 <= '0;
    end else begin
      automatic int d  = d_of(m_cfg[3:2]);
      automatic int vw = w_of(m_cfg[5:4]);
      automatic int nl = (m_line == LC) ? 1 : m_line + 1;
      e_hs <= !(m_pix < w_of(m_cfg[1:0]));
      if (!m_mode) begin
        if (m_line == F2 && m_pix == d + (m_cfg[4] ? HALF : 0)) e_fv <= 1'b0;
        else if (m_line == 1 && m_pix == d) e_fv <= 1'b1;
      end else begin
        e_fv <= !((m_line == 1 && m_pix >= d && m_pix < d + vw) ||
                  (m_line == F2 && m_pix >= HALF + d && m_pix < HALF + d + vw));
      end
      case (m_cfg[7:6])
        2'd0: e_dat <= din;
        2'd1: e_dat <= h0;
        2'd2: e_dat <= h1;
        default: e_dat <= h2;
      endcase
      h0 <= din; h1 <= h0; h2 <= h1;
      if (m_pix == LL - 1) begin
        m_pix <= 0; m_line <= nl; m_cfg <= cfg; m_mode <= mode;
        m_field <= (nl >= F2);
      end else begin
        m_pix <= m_pix + 1;
      end
    end
  end

  int err_hs, err_fv, err_dat, err_cnt;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hsync_n !== e_hs) err_hs++;
      if (fv !== e_fv) err_fv++;
      if (dout !== e_dat) err_dat++;
      if (int'(line) != m_line || int'(pixel) != m_pix || field !== m_field) err_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    din = '0;
    forever begin
      @(negedge clk);
      din = din + 8'd37;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; cfg = 8'hFF; mode = 1'b1;
    err_hs = 0; err_fv = 0; err_dat = 0; err_cnt = 0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(hsync_n == 1'b1, "R8", "hsync_n in reset", int'(hsync_n), 1);
    chk(fv == 1'b1, "R8", "fv in reset", int'(fv), 1);
    chk(dout == '0, "R8", "data in reset", int'(dout), 0);
    chk(line == 1 && pixel == 0 && field == 1'b0, "R8", "line in reset", int'(line), 1);
    rst_n = 1'b1;
    // R7: word and mode are not used before the first line start
    @(negedge clk);
    chk(hsync_n == 1'b0, "R7", "hsync_n at pixel 0", int'(hsync_n), 0);
    chk(fv == 1'b1, "R7", "fv mode not yet applied", int'(fv), 1);
    @(negedge clk);
    chk(hsync_n == 1'b1, "R7", "width 1 before first load", int'(hsync_n), 1);

    // Vector table walk
    for (int i = 0; i < 8; i++) begin
      automatic int lows = 0;
      automatic int got = -1;
      automatic logic pfv;
      cfg = VEC[i].cfg; mode = VEC[i].mode;
      repeat (2 * LL) @(negedge clk);
      err_hs = 0; err_fv = 0; err_dat = 0; err_cnt = 0;
      pfv = fv;
      for (int c = 0; c < LL * LC; c++) begin
        @(negedge clk);
        if (!hsync_n) lows++;
        if (pfv && !fv && int'(line) == VEC[i].fline && got < 0) got = int'(pixel);
        pfv = fv;
      end
      chk(lows == LC * VEC[i].hw, "R2", "hsync low clocks per frame", lows, LC * VEC[i].hw);
      chk(got == VEC[i].fpix, VEC[i].mode ? "R5" : "R4", "fv fall pixel (R3 offset)", got, VEC[i].fpix);
      chk(err_hs == 0, "R2", "hsync cycle mismatches", err_hs, 0);
      chk(err_fv == 0, VEC[i].mode ? "R5" : "R4", "fv cycle mismatches", err_fv, 0);
      chk(err_dat == 0, "R6", "data skew mismatches", err_dat, 0);
      chk(err_cnt == 0, "R1", "counter mismatches", err_cnt, 0);
    end

    // R7: a mid-line change waits for the next line
    cfg = 8'h00; mode = 1'b0;
    repeat (2 * LL) @(negedge clk);
    while (int'(pixel) != 20) @(negedge clk);
    cfg = 8'h03;
    begin
      automatic int lows = 0;
      @(negedge clk);
      while (int'(pixel) != 0) begin
        if (!hsync_n) lows++;
        @(negedge clk);
      end
      chk(lows == 0, "R7", "lows after mid-line change", lows, 0);
      lows = 0;
      for (int c = 0; c < LL; c++) begin
        @(negedge clk);
        if (!hsync_n) lows++;
      end
      chk(lows == 128, "R7", "lows on next line", lows, 128);
    end

    // R1: field flag and line wrap
    while (int'(line) != F2) @(negedge clk);
    chk(field == 1'b1, "R1", "field at second-field line", int'(field), 1);
    while (!(int'(line) == LC && int'(pixel) == LL - 1)) @(negedge clk);
    @(negedge clk);
    chk(int'(line) == 1 && int'(pixel) == 0, "R1", "line after wrap", int'(line), 1);
    chk(field == 1'b0, "R1", "field after wrap", int'(field), 0);

    // R8: asynchronous reset in the middle of a pulse
    @(negedge clk);
    chk(hsync_n == 1'b0, "R2", "hsync low before reset", int'(hsync_n), 0);
    #1 rst_n = 1'b0;
    #0.5;
    chk(hsync_n == 1'b1 && fv == 1'b1, "R8", "async reset of syncs", int'(hsync_n), 1);
    chk(int'(line) == 1 && int'(pixel) == 0 && dout == '0, "R8", "async reset of counters", int'(pixel), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    summary();
  end

endmodule